// File: doc/BRIEF.md
# Toggle-Handshake Elastic Queue

The block is a small FIFO that sits between two pipeline stages whose latencies vary. Both sides talk to it with transition-signalled handshakes. Any change of level on a go wire, up or down, is one request. A change on the matching ack wire is one acceptance. A side has a request outstanding exactly when its go and ack levels differ. The queue holds up to `DEPTH` words. This lets a fast producer run a few items ahead of a slow consumer, and lets a consumer drain while the producer is busy. `DEPTH` sets how much elasticity sits between the stages. It is typically 1 or 2.

The model is clocked. A request seen at a clock edge while there is space is stored at that edge, and the upstream ack flips at the same edge. If the queue was empty, the word is also offered downstream at that same edge, with a flip of the downstream go. The cost of passing through the queue is therefore one clock. When the downstream ack catches up with go, the head is dropped. The next stored word, if any, is offered at that same edge.

Top module: `hs_elastic_queue`

## Requirements
- R1: While reset is asserted and after its release, `up_ack` and `dn_go` are 0 and the queue holds no entries.
- R2: When `up_go` differs from `up_ack` and fewer than `DEPTH` entries are held, the next clock edge stores `up_data` and toggles `up_ack`. Rising and falling go transitions are treated alike.
- R3: `up_ack` changes only at an edge where `up_go` differed from `up_ack` beforehand.
- R4: While `DEPTH` entries are held, `up_ack` does not change. A pending request is accepted at the first edge after an entry has been dropped.
- R5: At the edge where the queue goes from empty to holding a word, `dn_go` toggles and `dn_data` shows that word. When the head is dropped and another word remains, `dn_go` toggles again at the same edge and `dn_data` shows the next word.
- R6: While `dn_go` differs from `dn_ack`, `dn_go` and `dn_data` hold their values.
- R7: A `dn_ack` transition that matches `dn_go` drops the head at the next edge. Words leave in the order they arrived.
- R8: With `DEPTH` = 2 and an idle consumer, two producer transfers complete and a third stays pending.
- R9: Occupancy never exceeds `DEPTH`. When the queue is empty, `dn_go` equals `dn_ack`.
- R10: In a non-full queue, a request and a downstream acceptance at the same edge both take effect: the new word is stored, the head is dropped, and the next word is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_go | input | 1 | Producer request phase; each transition is one request |
| up_ack | output | 1 | Producer acceptance phase |
| up_data | input | WIDTH | Producer word, valid while its request is pending |
| dn_go | output | 1 | Consumer request phase; each transition offers one word |
| dn_ack | input | 1 | Consumer acceptance phase |
| dn_data | output | WIDTH | Head word offered to the consumer |

## Verification
A wrong occupancy count shows up within one edge at the ports. A count stuck at full stops `up_ack` from ever following `up_go`. A count that fails to reach full lets a third word through on a depth-2 queue. A read pointer that advances at the wrong time puts a word out of order on `dn_data` at the edge where the following `dn_go` toggle appears. A lost offer event leaves `dn_go` equal to `dn_ack` while words are still queued, so the consumer sees nothing to take at the very next sample.

// File: rtl/hs_elastic_queue.sv
module hs_elastic_queue #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_go,
  output logic             up_ack,
  input  logic [WIDTH-1:0] up_data,
  output logic             dn_go,
  input  logic             dn_ack,
  output logic [WIDTH-1:0] dn_data
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST  = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic             up_ack_q, dn_go_q, dn_ack_seen;
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count, count_nx;
  logic [WIDTH-1:0] slot [DEPTH];

  logic req_evt, space, push, outstanding, ack_evt, pop, present;

  // phase difference = one pending event on each side
  assign req_evt     = up_go ^ up_ack_q;
  assign ack_evt     = dn_ack ^ dn_ack_seen;
  assign outstanding = dn_go_q ^ dn_ack_seen;
  assign space       = (count != FULLC);

  // join: request event and a free slot
  assign push = req_evt & space;
  // join: consumer acceptance and an offered head
  assign pop  = ack_evt & outstanding;

  assign count_nx = count + CW'(push) - CW'(pop);

  // merge: an offer fires on a fresh head after a drop, or on the first word into an empty queue
  assign present = (~outstanding | pop) & (count_nx != '0);

  // steer: the write event goes to exactly one slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && wr_ptr == PW'(i)) slot[i] <= up_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_ack_q    <= 1'b0;
      dn_go_q     <= 1'b0;
      dn_ack_seen <= 1'b0;
      wr_ptr      <= '0;
      rd_ptr      <= '0;
      count       <= '0;
    end else begin
      dn_ack_seen <= dn_ack;
      count       <= count_nx;
      if (push) begin
        up_ack_q <= ~up_ack_q;
        wr_ptr   <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (present) dn_go_q <= ~dn_go_q;
    end
  end

  // the next head is read from the slot the write may fill at the same edge
  logic [PW-1:0] head_idx;
  assign head_idx = pop ? ((rd_ptr == LAST) ? '0 : rd_ptr + 1'b1) : rd_ptr;

  logic [WIDTH-1:0] head_q;
  always_ff @(posedge clk) begin
    if (!rst_n) head_q <= '0;
    else if (present) head_q <= (push && wr_ptr == head_idx) ? up_data : slot[head_idx];
  end

  assign up_ack  = up_ack_q;
  assign dn_go   = dn_go_q;
  assign dn_data = head_q;

endmodule

// File: rtl/hs_elastic_queue_chk.sv
module hs_elastic_queue_chk #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             up_go,
  input logic             up_ack,
  input logic             dn_go,
  input logic             dn_ack,
  input logic [WIDTH-1:0] dn_data,
  input logic [$clog2(DEPTH+1)-1:0] count
);

  // R3
  ack_follows_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(up_go == up_ack) |-> $stable(up_ack));

  // R4
  full_holds_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == ($clog2(DEPTH+1))'(DEPTH)) |=> $stable(up_ack));

  // R6
  offer_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_go != dn_ack) |=> ($stable(dn_go) && $stable(dn_data)));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ($clog2(DEPTH+1))'(DEPTH));

  // R9
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (dn_go == dn_ack));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (!up_ack && !dn_go && count == '0));

endmodule

bind hs_elastic_queue hs_elastic_queue_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_go(up_go), .up_ack(up_ack),
  .dn_go(dn_go), .dn_ack(dn_ack), .dn_data(dn_data), .count(count)
);

// File: tb/sim_hs_elastic_queue.sv
module sim_hs_elastic_queue;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       up_go = 1'b0;
  logic       up_ack;
  logic [7:0] up_data = '0;
  logic       dn_go;
  logic       dn_ack = 1'b0;
  logic [7:0] dn_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  hs_elastic_queue #(.WIDTH(8), .DEPTH(2)) u0 (
    .clk(clk), .rst_n(rst_n), .up_go(up_go), .up_ack(up_ack), .up_data(up_data),
    .dn_go(dn_go), .dn_ack(dn_ack), .dn_data(dn_data)
  );

  typedef struct packed {
    logic       go;
    logic       ack;
    logic [7:0] din;
    logic       e_up_ack;
    logic       e_dn_go;
    logic       chk_data;
    logic [7:0] e_data;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [11] = '{
    vec_t'{1'b1, 1'b0, 8'hA1, 1'b1, 1'b1, 1'b1, 8'hA1, 4'd5}, // R5 first word offered
    vec_t'{1'b1, 1'b0, 8'hB2, 1'b0, 1'b1, 1'b1, 8'hA1, 4'd2}, // R2 falling go accepted
    vec_t'{1'b1, 1'b0, 8'hC3, 1'b0, 1'b1, 1'b1, 8'hA1, 4'd8}, // R8 third withheld
    vec_t'{1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'hA1, 4'd4}, // R4 still full
    vec_t'{1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'hB2, 4'd7}, // R7 drop, next offered
    vec_t'{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'hB2, 4'd4}, // R4 accept after space
    vec_t'{1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 8'hC3, 4'd7}, // R7 order kept
    vec_t'{1'b1, 1'b1, 8'hD4, 1'b0, 1'b0, 1'b1, 8'hD4, 4'd10}, // R10 push and pop
    vec_t'{1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 4'd9}, // R9 empty, go==ack
    vec_t'{1'b1, 1'b0, 8'hE5, 1'b1, 1'b1, 1'b1, 8'hE5, 4'd5}, // R5 refill
    vec_t'{1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 4'd9}  // R9 drained
  };

  task automatic check(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic tgo, input logic tack, input logic [7:0] d);
    @(negedge clk);
    if (tgo) begin
      up_go   = ~up_go;
      up_data = d;
    end
    if (tack) dn_ack = ~dn_ack;
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 during reset
    check(1, "up_ack in reset", {7'b0, up_ack}, 8'h0);
    check(1, "dn_go in reset", {7'b0, dn_go}, 8'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    // R1 after release
    check(1, "up_ack after reset", {7'b0, up_ack}, 8'h0);
    check(1, "dn_go after reset", {7'b0, dn_go}, 8'h0);

    for (int i = 0; i < 11; i++) begin
      step(VEC[i].go, VEC[i].ack, VEC[i].din);
      check(int'(VEC[i].req), "up_ack", {7'b0, up_ack}, {7'b0, VEC[i].e_up_ack});
      check(int'(VEC[i].req), "dn_go", {7'b0, dn_go}, {7'b0, VEC[i].e_dn_go});
      if (VEC[i].chk_data) check(int'(VEC[i].req), "dn_data", dn_data, VEC[i].e_data);
      check(9, "empty or offered: go vs ack", {7'b0, dn_go ^ dn_ack},
            {7'b0, (VEC[i].e_dn_go != dn_ack)});
    end

    // R6: offer held while consumer idles
    step(1'b1, 1'b0, 8'h66);
    repeat (3) begin
      step(1'b0, 1'b0, 8'h00);
      check(6, "held dn_data", dn_data, 8'h66);
      check(6, "held dn_go", {7'b0, dn_go}, {7'b0, ~dn_ack});
    end

    // R1: reset mid-operation clears phases
    @(negedge clk);
    rst_n = 1'b0;
    up_go = 1'b0;
    dn_ack = 1'b0;
    @(posedge clk);
    #2;
    check(1, "up_ack reset mid-run", {7'b0, up_ack}, 8'h0);
    check(1, "dn_go reset mid-run", {7'b0, dn_go}, 8'h0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 8'h00);
    // R3: no request, no ack change
    check(3, "idle up_ack", {7'b0, up_ack}, 8'h0);
    step(1'b1, 1'b0, 8'h77);
    check(2, "accept after reset", {7'b0, up_ack}, 8'h1);
    check(5, "first word after reset", dn_data, 8'h77);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule